// File: doc/BRIEF.md
# Half-Word Register Access Bridge

This block lets a host with a 16-bit data path reach a register block that only accepts full 32-bit accesses. When the host issues two half-word writes to the same word, the bridge holds the first one and then sends a single 32-bit write with both halves. A half-word read fetches the whole word downstream and keeps a copy. The other half of the pair is then served from that copy, so a register with a read side effect sees one read per word, not two. Full-word accesses go straight through and do not touch the pairing state.

A strap input sets 16-bit or 32-bit host mode at reset, and the selected mode is visible in bit 2 of a configuration register. The downstream register file is modelled inside the block as a 64-word memory. The configuration register sits at offset 0x74. A counter of downstream read strobes is brought out, so the number of real register reads can be observed directly.

Top module: `hw_bridge16`

## Requirements
- R1: Only address bits [7:0] are decoded, so an access at offset X+0x100 reaches the same register as X.
- R2: A 4-byte access (size code 4) writes or reads the full 32-bit word at address bits [7:2] and raises the read-strobe count by one for each read.
- R3: In 16-bit mode, the first half-word write (size code 2) to a word issues nothing downstream. The second one writes {high, low} to that word. Address bit 1 set selects the high half, clear selects the low half.
- R4: Two half-word writes to the same half of one word still complete the pair. The resulting word holds the latest value for that half and the last held value for the other half.
- R5: A half-word write to a different word than the pending one discards the pending pair and starts a new pair.
- R6: In 16-bit mode, the first half-word read of a pair performs one downstream read and keeps the word. The second read of the same word is served from the kept copy with no downstream read. Address bit 1 set returns bits [31:16], clear returns bits [15:0], zero-extended.
- R7: A half-word read to a different word than the pending one starts a new pair with a fresh downstream read.
- R8: The configuration register at offset 0x74 resets to 0x00050004 when strap_bus16 is 0 (32-bit mode) and to 0x00050000 when strap_bus16 is 1. Bit 2 then keeps its value until the next reset.
- R9: A write to the configuration register stores only the bits in mask 0x0003F300. Bit 2 is kept, and every other bit becomes 0.
- R10: An access whose size code is not 2 or 4, or that has size code 2 in 32-bit mode, raises host_err on the next cycle. It changes no register and returns no read data.
- R11: Reset clears the pending read pair, the pending write pair and the read-strobe count.
- R12: An accepted read presents host_rvalid and its data on the cycle after it is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_bus16 | input | 1 | 1 selects 16-bit host mode, sampled at reset |
| host_valid | input | 1 | Access request for this cycle |
| host_write | input | 1 | 1 for a write, 0 for a read |
| host_size | input | 3 | Access size in bytes |
| host_addr | input | ADDR_W | Byte address; only bits [7:0] are decoded |
| host_wdata | input | 32 | Write data; half-word writes use bits [15:0] |
| host_rdata | output | 32 | Read data |
| host_rvalid | output | 1 | Read data valid |
| host_err | output | 1 | Illegal access size on the previous cycle |
| rd_strobes | output | CNT_W | Number of downstream reads since reset |

## Verification
A wrong pair counter does not show up as a bad bit right away. It shows up one access later: a combined write that lands early or never lands, or a second half-read that returns freshly fetched data where the kept copy was expected. The bench therefore reads each word back in full after every write pairing. It also rewrites a word between the two half-reads, so a stale or missing copy becomes visible in the data. The read-strobe count exposes an extra or missing downstream read on the cycle after the access.

// File: rtl/hw_bridge16.sv
module hw_bridge16 #(
  parameter int          ADDR_W   = 16,
  parameter int          CNT_W    = 16,
  parameter logic [7:0]  CFG_OFS  = 8'h74,
  parameter logic [31:0] CFG_MASK = 32'h0003_F300,
  parameter logic [31:0] CFG_RST  = 32'h0005_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_bus16,
  input  logic              host_valid,
  input  logic              host_write,
  input  logic [2:0]        host_size,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_rvalid,
  output logic              host_err,
  output logic [CNT_W-1:0]  rd_strobes
);
  localparam int WORDS = 64;
  localparam logic [5:0] CFG_WORD = CFG_OFS[7:2];

  logic [31:0] mem [WORDS];
  logic [31:0] cfg_q, rd_hold;
  logic [15:0] lo_q, hi_q;
  logic [5:0]  wr_word, rd_word;
  logic        wr_cnt, rd_cnt;

  wire [5:0] word    = host_addr[7:2];
  wire       hi_sel  = host_addr[1];
  wire       mode16  = ~cfg_q[2];
  wire       is_full = host_size == 3'd4;
  wire       is_half = host_size == 3'd2 && mode16;
  wire       acc     = host_valid && (is_full || is_half);
  wire       half_wr = acc && is_half && host_write;
  wire       half_rd = acc && is_half && !host_write;

  wire wr_same = wr_cnt && wr_word == word;
  wire rd_same = rd_cnt && rd_word == word;
  wire wr_fire = half_wr && wr_same;
  wire rd_first = half_rd && !rd_same;

  wire [15:0] lo_next = (half_wr && !hi_sel) ? host_wdata[15:0] : lo_q;
  wire [15:0] hi_next = (half_wr &&  hi_sel) ? host_wdata[15:0] : hi_q;

  wire        dn_valid = acc && (is_full || wr_fire || rd_first);
  wire        dn_wr    = dn_valid && host_write;
  wire        dn_rd    = dn_valid && !host_write;
  wire [31:0] dn_wdata = is_full ? host_wdata : {hi_next, lo_next};
  wire [31:0] dn_rdata = (word == CFG_WORD) ? cfg_q : mem[word];
  wire [31:0] half_src = rd_first ? dn_rdata : rd_hold;
  wire [15:0] half_val = hi_sel ? half_src[31:16] : half_src[15:0];

  always_ff @(posedge clk) begin
    if (dn_wr && word != CFG_WORD) mem[word] <= dn_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= CFG_RST | (strap_bus16 ? 32'h0 : 32'h4);
      lo_q        <= '0;
      hi_q        <= '0;
      wr_word     <= '0;
      rd_word     <= '0;
      wr_cnt      <= 1'b0;
      rd_cnt      <= 1'b0;
      rd_hold     <= '0;
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
      host_err    <= 1'b0;
      rd_strobes  <= '0;
    end else begin
      host_err    <= host_valid && !acc;
      host_rvalid <= acc && !host_write;
      if (dn_wr && word == CFG_WORD) cfg_q <= (dn_wdata & CFG_MASK) | (cfg_q & 32'h4);
      if (dn_rd) rd_strobes <= rd_strobes + 1'b1;
      if (half_wr) begin
        lo_q    <= lo_next;
        hi_q    <= hi_next;
        wr_word <= word;
        wr_cnt  <= !wr_same;
      end
      if (half_rd) begin
        rd_word <= word;
        rd_cnt  <= !rd_same;
      end
      if (rd_first) rd_hold <= dn_rdata;
      if (acc && !host_write) host_rdata <= is_full ? dn_rdata : {16'h0, half_val};
    end
  end
endmodule

// File: rtl/hw_bridge16_chk.sv
module hw_bridge16_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_valid,
  input logic              host_write,
  input logic [2:0]        host_size,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_rvalid,
  input logic              host_err,
  input logic [CNT_W-1:0]  rd_strobes,
  input logic              wr_cnt,
  input logic              rd_cnt,
  input logic [5:0]        rd_word,
  input logic              mode_bit
);
  wire bad_size = host_size != 3'd4 && (host_size != 3'd2 || mode_bit);

  assert_rvalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_write && !bad_size) |=> host_rvalid);

  assert_bad_size_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && bad_size) |=> (host_err && !host_rvalid));

  assert_strobe_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rd_strobes == $past(rd_strobes) || rd_strobes == $past(rd_strobes) + 1'b1));

  assert_cached_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid && !host_write && host_size == 3'd2 && !mode_bit && rd_cnt
     && rd_word == host_addr[7:2]) |=> $stable(rd_strobes));

  assert_mode_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mode_bit));

  assert_pairs_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!wr_cnt && !rd_cnt));
endmodule

bind hw_bridge16 hw_bridge16_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
  .host_size(host_size), .host_addr(host_addr), .host_rvalid(host_rvalid),
  .host_err(host_err), .rd_strobes(rd_strobes), .wr_cnt(wr_cnt),
  .rd_cnt(rd_cnt), .rd_word(rd_word), .mode_bit(cfg_q[2])
);

// File: tb/hw_bridge16_tb.sv
module hw_bridge16_tb;
  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_bus16 = 1'b1;
  logic host_valid = 1'b0, host_write = 1'b0;
  logic [2:0] host_size = 3'd4;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic host_rvalid, host_err;
  logic [CNT_W-1:0] rd_strobes;

  int checks = 0, errors = 0;
  logic [31:0] got;
  logic got_err, got_rv;

  always #4 clk = ~clk;

  hw_bridge16 #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .strap_bus16(strap_bus16),
    .host_valid(host_valid), .host_write(host_write), .host_size(host_size),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .host_err(host_err), .rd_strobes(rd_strobes));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic bus16);
    @(negedge clk);
    strap_bus16 = bus16;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic access(input logic wr, input logic [2:0] sz, input logic [15:0] addr,
                        input logic [31:0] data);
    @(negedge clk);
    host_valid = 1'b1; host_write = wr; host_size = sz;
    host_addr = addr; host_wdata = data;
    @(negedge clk);
    host_valid = 1'b0;
    got = host_rdata; got_err = host_err; got_rv = host_rvalid;
  endtask

  task automatic wr32(input logic [15:0] a, input logic [31:0] d); access(1'b1, 3'd4, a, d); endtask
  task automatic wr16(input logic [15:0] a, input logic [15:0] d); access(1'b1, 3'd2, a, {16'h0, d}); endtask
  task automatic rd32(input logic [15:0] a); access(1'b0, 3'd4, a, 32'h0); endtask
  task automatic rd16(input logic [15:0] a); access(1'b0, 3'd2, a, 32'h0); endtask

  task automatic t_reset;
    do_reset(1'b1);
    check("R11 strobes after reset", 32'(rd_strobes), 32'h0);
    rd32(16'h0074);
    check("R8 cfg reset 16-bit", got, 32'h0005_0000);
    check("R12 rvalid", {31'h0, got_rv}, 32'h1);
  endtask

  task automatic t_full;
    logic [CNT_W-1:0] s0;
    wr32(16'h0020, 32'hDEAD_BEEF);
    s0 = rd_strobes;
    rd32(16'h0020);
    check("R2 full read", got, 32'hDEAD_BEEF);
    check("R2 one strobe", 32'(rd_strobes - s0), 32'h1);
  endtask

  task automatic t_alias;
    rd32(16'h0120);
    check("R1 alias read", got, 32'hDEAD_BEEF);
    wr32(16'h0324, 32'h1122_3344);
    rd32(16'h0024);
    check("R1 alias write", got, 32'h1122_3344);
  endtask

  task automatic t_half_write;
    wr32(16'h0040, 32'h0);
    wr16(16'h0042, 16'hCAFE);
    rd32(16'h0040);
    check("R3 no write after first half", got, 32'h0);
    wr16(16'h0040, 16'h1234);
    rd32(16'h0040);
    check("R3 combined hi first", got, 32'hCAFE_1234);
    wr16(16'h0044, 16'h5678);
    wr16(16'h0046, 16'hBEEF);
    rd32(16'h0044);
    check("R3 combined lo first", got, 32'hBEEF_5678);
  endtask

  task automatic t_same_half;
    wr32(16'h0048, 32'h0);
    wr16(16'h0048, 16'h1111);
    wr16(16'h0048, 16'h2222);
    rd32(16'h0048);
    check("R4 same half twice", got, 32'hBEEF_2222);
  endtask

  task automatic t_new_word;
    wr32(16'h0050, 32'h0);
    wr32(16'h0054, 32'h0);
    wr16(16'h0050, 16'hAAAA);
    wr16(16'h0054, 16'hBBBB);
    rd32(16'h0050);
    check("R5 abandoned pair", got, 32'h0);
    rd32(16'h0054);
    check("R5 new pair pending", got, 32'h0);
    wr16(16'h0056, 16'hCCCC);
    rd32(16'h0054);
    check("R5 new pair done", got, 32'hCCCC_BBBB);
  endtask

  task automatic t_half_read;
    logic [CNT_W-1:0] s0;
    wr32(16'h0060, 32'h89AB_CDEF);
    s0 = rd_strobes;
    rd16(16'h0060);
    check("R6 low half", got, 32'h0000_CDEF);
    check("R6 first fetch", 32'(rd_strobes - s0), 32'h1);
    wr32(16'h0060, 32'h0);
    rd16(16'h0062);
    check("R6 high half from copy", got, 32'h0000_89AB);
    check("R6 no second fetch", 32'(rd_strobes - s0), 32'h1);
  endtask

  task automatic t_read_restart;
    logic [CNT_W-1:0] s0;
    wr32(16'h0064, 32'h5566_7788);
    s0 = rd_strobes;
    rd16(16'h0062);
    check("R7 fresh pair", got, 32'h0);
    rd16(16'h0066);
    check("R7 new word data", got, 32'h0000_5566);
    check("R7 new word fetch", 32'(rd_strobes - s0), 32'h2);
    rd16(16'h0064);
    check("R7 pair completes", got, 32'h0000_7788);
    check("R7 no extra fetch", 32'(rd_strobes - s0), 32'h2);
  endtask

  task automatic t_cfg;
    wr32(16'h0074, 32'hFFFF_FFFF);
    rd32(16'h0074);
    check("R9 masked write 16-bit", got, 32'h0003_F300);
    wr32(16'h0074, 32'h0);
    rd32(16'h0074);
    check("R9 clear", got, 32'h0);
  endtask

  task automatic t_err;
    logic [CNT_W-1:0] s0;
    access(1'b1, 3'd1, 16'h0020, 32'h0);
    check("R10 err size 1", {31'h0, got_err}, 32'h1);
    rd32(16'h0020);
    check("R10 no write", got, 32'hDEAD_BEEF);
    check("R10 err clears", {31'h0, got_err}, 32'h0);
    s0 = rd_strobes;
    access(1'b0, 3'd3, 16'h0020, 32'h0);
    check("R10 err size 3", {31'h0, got_err}, 32'h1);
    check("R10 no rvalid", {31'h0, got_rv}, 32'h0);
    check("R10 no strobe", 32'(rd_strobes - s0), 32'h0);
  endtask

  task automatic t_reset_pairs;
    wr32(16'h0070, 32'h0);
    wr16(16'h0070, 16'h7777);
    rd16(16'h0060);
    do_reset(1'b1);
    wr16(16'h0072, 16'h9999);
    rd32(16'h0070);
    check("R11 write pair cleared", got, 32'h0);
    wr16(16'h0070, 16'h1234);
    rd32(16'h0070);
    check("R11 new pair", got, 32'h9999_1234);
    wr32(16'h0060, 32'hA5A5_5A5A);
    rd16(16'h0062);
    check("R11 read pair cleared", got, 32'h0000_A5A5);
    check("R11 fetch counted", 32'(rd_strobes), 32'h3);
  endtask

  task automatic t_mode32;
    do_reset(1'b0);
    rd32(16'h0074);
    check("R8 cfg reset 32-bit", got, 32'h0005_0004);
    wr32(16'h0074, 32'h0);
    rd32(16'h0074);
    check("R9 bit2 kept", got, 32'h0000_0004);
    wr32(16'h0030, 32'h0);
    wr16(16'h0030, 16'h1234);
    check("R10 half in 32-bit mode", {31'h0, got_err}, 32'h1);
    wr16(16'h0032, 16'h5678);
    rd32(16'h0030);
    check("R10 no half write 32-bit", got, 32'h0);
  endtask

  initial begin
    fork
      begin
        t_reset; t_full; t_alias; t_half_write; t_same_half; t_new_word;
        t_half_read; t_read_restart; t_cfg; t_err; t_reset_pairs; t_mode32;
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule